// File: doc/BRIEF.md
# Interrupt Privilege Check Unit

This block decides, for a protected-mode processor, what happens when an interrupt or exception arrives. It also decides what happens when an interrupt-return instruction pops a code selector. For an event it is given four things: the current privilege level, the kind of event, the fields of the gate descriptor already fetched from the descriptor table, and the fields of the code segment that the gate points at. It answers with an accept or fault verdict and a fault code. It also gives the privilege level the handler will run at, whether the stack must be switched and to which SS:ESP, and whether a task switch must be requested instead.

The per-level stack pointers for levels 0, 1 and 2 live in a small register file inside the block. Software loads it through a dedicated write port that takes a level index. Descriptor fetch, the pushes onto the new stack and the task state save are done by other parts of the processor. The block only issues the decision.

A request is presented with a one-cycle strobe. The decision appears on registered outputs one cycle later and is held until the next request.

Top module: `intr_priv_unit`

## Requirements
- R1: After reset all outputs are zero. When `req_valid` is high at a rising edge, `rsp_valid` is high during the following cycle only, and the other outputs then show that request's decision until the next request. On a fault, `accept`=0, `new_pl` equals `cur_pl`, and `stack_switch`, `task_switch`, `new_ss` and `new_esp` are 0. On acceptance `fault_code`=0.
- R2: For an event, a not-present fault (`fault_code`=2) is raised when `gate_present` is 0, or when the gate is not a task gate and `seg_present` is 0. This check takes priority over every privilege check.
- R3: Only a software interrupt (`ev_kind`=0) checks the gate: it faults with general protection (`fault_code`=1) when `cur_pl` > `gate_dpl`. For external interrupts (1) and processor exceptions (2, and 3 treated the same), `gate_dpl` has no effect.
- R4: For any event kind through an interrupt or trap gate, a target segment with `seg_dpl` > `cur_pl` causes a general-protection fault.
- R5: For a non-conforming target with `seg_dpl` < `cur_pl`, the event is accepted with `new_pl`=`seg_dpl`, `stack_switch`=1, and `new_ss`/`new_esp` taken from the stack slot of level `seg_dpl`.
- R6: For a non-conforming target with `seg_dpl` equal to `cur_pl`, the event is accepted at that level with no stack switch and `new_ss`/`new_esp` at 0. In particular, no stack switch ever occurs at `cur_pl`=0.
- R7: A conforming target (`seg_conforming`=1) that passes R4 is accepted with `new_pl`=`cur_pl` and no stack switch.
- R8: A task gate (`gate_kind`=2) that passes R2 and R3 is accepted with `task_switch`=1, `new_pl`=`cur_pl` and no stack switch. The target segment fields are ignored.
- R9: A reserved gate kind (`gate_kind`=3) that is present causes a general-protection fault. Interrupt gate (0) and trap gate (1) are handled alike.
- R10: A return request (`req_is_return`=1) faults not-present when `seg_present` is 0. For a non-conforming segment, it faults general-protection when `seg_dpl` differs from the selector's RPL (`ret_sel[1:0]`). Otherwise it is accepted with `new_pl` equal to that RPL and no stack or task switch.
- R11: `sp_we` with `sp_idx` 0 to 2 loads `sp_ss`/`sp_esp` into that level's slot at the rising edge. Index 3 writes nothing. A request in the same cycle as a write still sees the old slot contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_is_return | input | 1 | 1 = interrupt-return check, 0 = event entry |
| cur_pl | input | 2 | Current privilege level |
| ev_kind | input | 2 | 0 software INT, 1 external interrupt, 2/3 exception |
| gate_kind | input | 2 | 0 interrupt gate, 1 trap gate, 2 task gate, 3 reserved |
| gate_dpl | input | 2 | Gate descriptor privilege level |
| gate_present | input | 1 | Gate present bit |
| seg_dpl | input | 2 | Target code segment privilege level |
| seg_conforming | input | 1 | Target code segment conforming bit |
| seg_present | input | 1 | Target code segment present bit |
| ret_sel | input | 16 | Code selector popped by interrupt return |
| sp_we | input | 1 | Stack slot write enable |
| sp_idx | input | 2 | Stack slot level index |
| sp_ss | input | 16 | Stack segment selector to store |
| sp_esp | input | 32 | Stack pointer to store |
| rsp_valid | output | 1 | Decision valid pulse |
| accept | output | 1 | Request accepted |
| fault_code | output | 2 | 0 none, 1 general protection, 2 not present |
| new_pl | output | 2 | Privilege level after the transfer |
| stack_switch | output | 1 | Load new SS:ESP |
| new_ss | output | 16 | New stack segment selector |
| new_esp | output | 32 | New stack pointer |
| task_switch | output | 1 | Task switch requested |

## Verification
The bench goes after the priority between checks. A design that tests privilege before presence would report GP where NP is due. One that checks `gate_dpl` for hardware events would fault external interrupts raised from user level. It also targets the stack-switch boundary. A design that switches on equal levels, or at level 0, would emit a nonzero `new_ss` and set the flag. A design that reads the wrong slot would hand back another ring's stack. The return path is probed with conforming segments, where an RPL check would wrongly fault. A write to index 3 and a write that lands in the same cycle as a request both expose a slot file that decodes its index or its timing badly.

// File: rtl/intr_priv_pkg.sv
package intr_priv_pkg;

  localparam int PL_W = 2;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_NP   = 2'd2
  } flt_e;

  localparam logic [1:0] EV_SOFT   = 2'd0;
  localparam logic [1:0] GK_TASK   = 2'd2;
  localparam logic [1:0] GK_RSVD   = 2'd3;

  typedef struct packed {
    logic            accept;
    flt_e            fault;
    logic [PL_W-1:0] new_pl;
    logic            stk_sw;
    logic            task_sw;
  } verdict_t;

  function automatic logic [PL_W-1:0] sel_rpl(input logic [15:0] sel);
    return sel[PL_W-1:0];
  endfunction

  // numerically lower level = more privileged
  function automatic logic more_priv(input logic [PL_W-1:0] a, input logic [PL_W-1:0] b);
    return a < b;
  endfunction

  function automatic verdict_t fault_v(input flt_e f, input logic [PL_W-1:0] pl);
    verdict_t v;
    v.accept  = 1'b0;
    v.fault   = f;
    v.new_pl  = pl;
    v.stk_sw  = 1'b0;
    v.task_sw = 1'b0;
    return v;
  endfunction

  function automatic verdict_t ok_v(input logic [PL_W-1:0] pl, input logic sw, input logic tsk);
    verdict_t v;
    v.accept  = 1'b1;
    v.fault   = FLT_NONE;
    v.new_pl  = pl;
    v.stk_sw  = sw;
    v.task_sw = tsk;
    return v;
  endfunction

endpackage

// File: rtl/priv_stack_file.sv
module priv_stack_file #(
  parameter int ENTRIES = 3,
  parameter int SS_W    = 16,
  parameter int ESP_W   = 32,
  localparam int IDX_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [SS_W-1:0]  wss,
  input  logic [ESP_W-1:0] wesp,
  input  logic [IDX_W-1:0] ridx,
  output logic [SS_W-1:0]  rss,
  output logic [ESP_W-1:0] resp
);

  logic [SS_W-1:0]  ss_q  [ENTRIES];
  logic [ESP_W-1:0] esp_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic hit;
    assign hit = we && (widx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ss_q[g]  <= '0;
        esp_q[g] <= '0;
      end else if (hit) begin
        ss_q[g]  <= wss;
        esp_q[g] <= wesp;
      end
    end
  end

  always_comb begin
    rss  = '0;
    resp = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ridx == IDX_W'(i)) begin
        rss  = ss_q[i];
        resp = esp_q[i];
      end
    end
  end

endmodule

// File: rtl/priv_entry_check.sv
module priv_entry_check
  import intr_priv_pkg::*;
(
  input  logic [PL_W-1:0] cur_pl,
  input  logic [1:0]      ev_kind,
  input  logic [1:0]      gate_kind,
  input  logic [PL_W-1:0] gate_dpl,
  input  logic            gate_present,
  input  logic [PL_W-1:0] seg_dpl,
  input  logic            seg_conforming,
  input  logic            seg_present,
  output verdict_t        v
);

  logic is_task, not_present, gate_denied, seg_denied;

  assign is_task     = (gate_kind == GK_TASK);
  assign not_present = !gate_present || (!is_task && !seg_present);
  assign gate_denied = (ev_kind == EV_SOFT) && more_priv(gate_dpl, cur_pl);
  assign seg_denied  = more_priv(cur_pl, seg_dpl);

  always_comb begin
    if (not_present)                 v = fault_v(FLT_NP, cur_pl);
    else if (gate_kind == GK_RSVD)   v = fault_v(FLT_GP, cur_pl);
    else if (gate_denied)            v = fault_v(FLT_GP, cur_pl);
    else if (is_task)                v = ok_v(cur_pl, 1'b0, 1'b1);
    else if (seg_denied)             v = fault_v(FLT_GP, cur_pl);
    else if (seg_conforming)         v = ok_v(cur_pl, 1'b0, 1'b0);
    else                             v = ok_v(seg_dpl, more_priv(seg_dpl, cur_pl), 1'b0);
  end

endmodule

// File: rtl/priv_return_check.sv
module priv_return_check
  import intr_priv_pkg::*;
(
  input  logic [PL_W-1:0] cur_pl,
  input  logic [15:0]     ret_sel,
  input  logic [PL_W-1:0] seg_dpl,
  input  logic            seg_conforming,
  input  logic            seg_present,
  output verdict_t        v
);

  logic [PL_W-1:0] rpl;
  logic            rpl_mismatch;

  assign rpl          = sel_rpl(ret_sel);
  assign rpl_mismatch = !seg_conforming && (seg_dpl != rpl);

  always_comb begin
    if (!seg_present)      v = fault_v(FLT_NP, cur_pl);
    else if (rpl_mismatch) v = fault_v(FLT_GP, cur_pl);
    else                   v = ok_v(rpl, 1'b0, 1'b0);
  end

endmodule

// File: rtl/intr_priv_unit.sv
module intr_priv_unit
  import intr_priv_pkg::*;
#(
  parameter int SS_W    = 16,
  parameter int ESP_W   = 32,
  parameter int STK_LVL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_is_return,
  input  logic [1:0]       cur_pl,
  input  logic [1:0]       ev_kind,
  input  logic [1:0]       gate_kind,
  input  logic [1:0]       gate_dpl,
  input  logic             gate_present,
  input  logic [1:0]       seg_dpl,
  input  logic             seg_conforming,
  input  logic             seg_present,
  input  logic [15:0]      ret_sel,
  input  logic             sp_we,
  input  logic [1:0]       sp_idx,
  input  logic [SS_W-1:0]  sp_ss,
  input  logic [ESP_W-1:0] sp_esp,
  output logic             rsp_valid,
  output logic             accept,
  output logic [1:0]       fault_code,
  output logic [1:0]       new_pl,
  output logic             stack_switch,
  output logic [SS_W-1:0]  new_ss,
  output logic [ESP_W-1:0] new_esp,
  output logic             task_switch
);

  verdict_t        ent_v, ret_v, pick_v;
  logic [SS_W-1:0] slot_ss;
  logic [ESP_W-1:0] slot_esp;

  priv_stack_file #(.ENTRIES(STK_LVL), .SS_W(SS_W), .ESP_W(ESP_W)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .we(sp_we), .widx(sp_idx), .wss(sp_ss), .wesp(sp_esp),
    .ridx(seg_dpl), .rss(slot_ss), .resp(slot_esp)
  );

  priv_entry_check u_ent (
    .cur_pl(cur_pl), .ev_kind(ev_kind), .gate_kind(gate_kind),
    .gate_dpl(gate_dpl), .gate_present(gate_present),
    .seg_dpl(seg_dpl), .seg_conforming(seg_conforming),
    .seg_present(seg_present), .v(ent_v)
  );

  priv_return_check u_ret (
    .cur_pl(cur_pl), .ret_sel(ret_sel), .seg_dpl(seg_dpl),
    .seg_conforming(seg_conforming), .seg_present(seg_present), .v(ret_v)
  );

  assign pick_v = req_is_return ? ret_v : ent_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      accept       <= 1'b0;
      fault_code   <= 2'd0;
      new_pl       <= 2'd0;
      stack_switch <= 1'b0;
      new_ss       <= '0;
      new_esp      <= '0;
      task_switch  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        accept       <= pick_v.accept;
        fault_code   <= pick_v.fault;
        new_pl       <= pick_v.new_pl;
        stack_switch <= pick_v.stk_sw;
        new_ss       <= pick_v.stk_sw ? slot_ss  : '0;
        new_esp      <= pick_v.stk_sw ? slot_esp : '0;
        task_switch  <= pick_v.task_sw;
      end
    end
  end

  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_np_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_return && !gate_present) |=> (fault_code == 2'd2 && !accept));

  assert_hw_ignores_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_return && ev_kind != 2'd0 && gate_present && gate_kind == 2'd2)
    |=> task_switch);

  assert_switch_inward_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && stack_switch) |-> (new_pl < $past(cur_pl) && accept && !task_switch));

  assert_no_switch_ring0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_pl == 2'd0) |=> !stack_switch);

  assert_ret_rpl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_return && seg_present && !seg_conforming && seg_dpl != ret_sel[1:0])
    |=> (fault_code == 2'd1));

endmodule

// File: tb/sim_intr_priv_unit.sv
module sim_intr_priv_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_is_return = 0;
  logic [1:0]  cur_pl = 0, ev_kind = 0, gate_kind = 0, gate_dpl = 0, seg_dpl = 0;
  logic        gate_present = 0, seg_conforming = 0, seg_present = 0;
  logic [15:0] ret_sel = 0;
  logic        sp_we = 0;
  logic [1:0]  sp_idx = 0;
  logic [15:0] sp_ss = 0;
  logic [31:0] sp_esp = 0;
  logic        rsp_valid, accept, stack_switch, task_switch;
  logic [1:0]  fault_code, new_pl;
  logic [15:0] new_ss;
  logic [31:0] new_esp;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_ss [3];
  logic [31:0] m_esp[3];

  logic        e_acc, e_sw, e_task;
  logic [1:0]  e_flt, e_pl;
  logic [15:0] e_ss;
  logic [31:0] e_esp;
  string       e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_priv_unit u0 (.*);

  function automatic void expect_calc();
    e_acc = 0; e_flt = 2'd0; e_pl = cur_pl; e_sw = 0; e_task = 0; e_ss = 0; e_esp = 0;
    if (req_is_return) begin
      e_tag = "R10";
      if (!seg_present) e_flt = 2'd2;
      else if (!seg_conforming && seg_dpl != ret_sel[1:0]) e_flt = 2'd1;
      else begin e_acc = 1; e_pl = ret_sel[1:0]; end
    end else if (!gate_present || (gate_kind != 2 && !seg_present)) begin
      e_tag = "R2"; e_flt = 2'd2;
    end else if (gate_kind == 3) begin
      e_tag = "R9"; e_flt = 2'd1;
    end else if (ev_kind == 0 && cur_pl > gate_dpl) begin
      e_tag = "R3"; e_flt = 2'd1;
    end else if (gate_kind == 2) begin
      e_tag = "R8"; e_acc = 1; e_task = 1;
    end else if (seg_dpl > cur_pl) begin
      e_tag = "R4"; e_flt = 2'd1;
    end else if (seg_conforming) begin
      e_tag = "R7"; e_acc = 1;
    end else if (seg_dpl < cur_pl) begin
      e_tag = "R5"; e_acc = 1; e_pl = seg_dpl; e_sw = 1;
      e_ss = m_ss[seg_dpl]; e_esp = m_esp[seg_dpl];
    end else begin
      e_tag = "R6"; e_acc = 1; e_pl = seg_dpl;
    end
  endfunction

  task automatic check_out(input string tag);
    n_chk++;
    if (rsp_valid !== 1 || accept !== e_acc || fault_code !== e_flt || new_pl !== e_pl ||
        stack_switch !== e_sw || task_switch !== e_task || new_ss !== e_ss || new_esp !== e_esp) begin
      n_bad++;
      $display("FAIL %s: got v%0b a%0b f%0d pl%0d sw%0b t%0b ss%h esp%h exp v1 a%0b f%0d pl%0d sw%0b t%0b ss%h esp%h",
        tag, rsp_valid, accept, fault_code, new_pl, stack_switch, task_switch, new_ss, new_esp,
        e_acc, e_flt, e_pl, e_sw, e_task, e_ss, e_esp);
    end
  endtask

  task automatic write_slot(input logic [1:0] idx, input logic [15:0] s, input logic [31:0] e);
    sp_we = 1; sp_idx = idx; sp_ss = s; sp_esp = e;
    @(negedge clk);
    sp_we = 0;
    if (idx < 3) begin m_ss[idx] = s; m_esp[idx] = e; end
  endtask

  task automatic apply(input logic rt, input logic [1:0] cp, input logic [1:0] ek,
                       input logic [1:0] gk, input logic [1:0] gd, input logic gp,
                       input logic [1:0] sd, input logic sc, input logic sp,
                       input logic [15:0] rs);
    req_is_return = rt; cur_pl = cp; ev_kind = ek; gate_kind = gk; gate_dpl = gd;
    gate_present = gp; seg_dpl = sd; seg_conforming = sc; seg_present = sp; ret_sel = rs;
    expect_calc();
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check_out(e_tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin m_ss[i] = 0; m_esp[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (rsp_valid !== 0 || accept !== 0 || fault_code !== 0 || new_pl !== 0 ||
        stack_switch !== 0 || task_switch !== 0 || new_ss !== 0 || new_esp !== 0) begin
      n_bad++; $display("FAIL R1: got nonzero outputs in reset exp all zero");
    end
    rst_n = 1;
    @(negedge clk);
    // R11: load slots, index 3 must not disturb them
    write_slot(2'd0, 16'h0010, 32'h0009_F000);
    write_slot(2'd1, 16'h0021, 32'h0008_E000);
    write_slot(2'd2, 16'h0032, 32'h0007_D000);
    write_slot(2'd3, 16'hBEEF, 32'hDEAD_BEEF);
    apply(0, 3, 1, 0, 0, 1, 0, 0, 1, 0);   // R5 / R11 slot 0
    apply(0, 3, 2, 1, 0, 1, 1, 0, 1, 0);   // R5 / R11 slot 1
    apply(0, 3, 1, 0, 0, 1, 2, 0, 1, 0);   // R5 / R11 slot 2
    n_chk++;
    @(negedge clk);
    if (rsp_valid !== 0) begin n_bad++; $display("FAIL R1: got rsp_valid 1 exp 0 after pulse"); end
    // R2: presence beats privilege
    apply(0, 3, 0, 0, 0, 0, 0, 0, 1, 0);
    apply(0, 3, 0, 0, 3, 1, 3, 0, 0, 0);
    // R3: gate dpl only for software INT
    apply(0, 3, 0, 0, 0, 1, 0, 0, 1, 0);
    apply(0, 3, 1, 1, 0, 1, 0, 0, 1, 0);
    // R4: outward target faults for hardware event
    apply(0, 1, 1, 0, 3, 1, 2, 0, 1, 0);
    // R6: same level, ring 0
    apply(0, 0, 0, 0, 3, 1, 0, 0, 1, 0);
    // R7: conforming stays at current level
    apply(0, 3, 0, 1, 3, 1, 0, 1, 1, 0);
    // R8: task gate ignores segment fields
    apply(0, 3, 2, 2, 0, 1, 3, 0, 0, 0);
    // R9: reserved gate kind
    apply(0, 0, 1, 3, 3, 1, 0, 0, 1, 0);
    // R10: return checks
    apply(1, 0, 0, 0, 0, 0, 3, 0, 1, 16'h001B);
    apply(1, 0, 0, 0, 0, 0, 0, 0, 1, 16'h001B);
    apply(1, 0, 0, 0, 0, 0, 0, 1, 1, 16'h001B);
    apply(1, 0, 0, 0, 0, 0, 3, 0, 0, 16'h001B);
    // R11: write in same cycle as request is not seen
    req_is_return = 0; cur_pl = 3; ev_kind = 1; gate_kind = 0; gate_dpl = 0;
    gate_present = 1; seg_dpl = 0; seg_conforming = 0; seg_present = 1;
    expect_calc();
    req_valid = 1; sp_we = 1; sp_idx = 0; sp_ss = 16'h0ABC; sp_esp = 32'h1234_5678;
    @(negedge clk);
    req_valid = 0; sp_we = 0;
    check_out("R11");
    m_ss[0] = 16'h0ABC; m_esp[0] = 32'h1234_5678;
    apply(0, 2, 1, 0, 0, 1, 0, 0, 1, 0);   // R11 new value now visible
    // random mix
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 8) == 0)
        write_slot(2'($urandom), 16'($urandom), $urandom);
      apply(1'($urandom % 4 == 0), 2'($urandom), 2'($urandom), 2'($urandom),
            2'($urandom), 1'($urandom % 8 != 0), 2'($urandom), 1'($urandom % 4 == 0),
            1'($urandom % 8 != 0), 16'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule